// File: doc/BRIEF.md
# Cyclic Signed-Digit Converter Sequencer

This block is the digital half of a cyclic analog-to-digital converter that resolves one redundant signed digit per cycle. A trigger starts a conversion of a fixed number of decision cycles. In each decision cycle the block reads two comparator outputs and turns them into a digit of -1, 0 or +1. One comparator watches for a residue above the upper threshold and the other for a residue below the lower threshold. From that digit it registers the switch-network code that tells the doubling stage whether to subtract the reference, add it, or pass the residue unchanged in the next cycle.

The digits are not plain bits. Each is weighted by a power of two and summed into a signed running total, so a wrong early decision is corrected by later digits. After the last decision the block adds half of full scale, clamps the sum to the unsigned output range, and presents the word with a one-clock ready pulse. A flag travels with the word and reports that some cycle saw both comparators asserted, which is a condition that should not occur.

Top module: `rsd_cyclic_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, sw_sel is 2'b00, result is 0, data_rdy is 0 and conv_err is 0.
- R2: A trigger sampled high at a clock edge while idle starts a conversion. The next NCYC edges (default 12) sample the comparators, and data_rdy is high during the cycle that follows the NCYC-th decision edge.
- R3: A trigger sampled while a conversion is in progress, including on its final decision edge, has no effect. Exactly one data_rdy pulse is produced, and the result is that of the original conversion.
- R4: Digit decoding is as follows. cmp_hi alone gives +1, cmp_lo alone gives -1, and neither gives 0.
- R5: Both comparators high in a decision cycle counts as digit 0. conv_err is 1 with the result of that conversion, and it returns to 0 after a later conversion that has no such cycle.
- R6: After each decision edge except the last, sw_sel holds the code for that digit: 2'b01 (subtract reference) for +1, 2'b10 (add reference) for -1, and 2'b00 (pass) for 0. sw_sel is 2'b00 whenever no conversion is running and is never 2'b11.
- R7: result equals 2^(RES_W-1) plus the sum of d_i*2^(NCYC-1-i), where d_0 is the first decision of the conversion.
- R8: The value of R7 is clamped, so a sum below 0 gives 0 and a sum above 2^RES_W-1 gives 2^RES_W-1 (4095 by default).
- R9: data_rdy is high for exactly one clock. result and conv_err stay unchanged until the next data_rdy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Conversion start request |
| cmp_hi | input | 1 | Residue above upper threshold |
| cmp_lo | input | 1 | Residue below lower threshold |
| sw_sel | output | 2 | Residue switch code: 00 pass, 01 subtract, 10 add |
| result | output | RES_W | Corrected, clamped conversion word |
| data_rdy | output | 1 | One-clock completion pulse |
| conv_err | output | 1 | Both comparators seen high during the conversion |

## Verification
The trigger is sampled on one edge and the comparators on each of the following NCYC edges. sw_sel changes on the same edge as the decision it encodes. data_rdy, result and conv_err change together on the NCYC-th decision edge. The bench drives all inputs on the falling edge and holds a behavioural integer model that advances on the rising edge. On every falling edge it compares all four outputs with that model, which means each output is checked in the same cycle the model predicts it. At each completion it also checks the word against a closed-form sum of the digits it drove. It checks the held values once more one cycle later.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  typedef enum logic [1:0] {
    SW_PASS = 2'b00,
    SW_SUB  = 2'b01,
    SW_ADD  = 2'b10
  } sw_code_e;

  typedef logic signed [1:0] digit_t;

  // ternary decision from the two threshold comparators
  function automatic digit_t decide(input logic hi, input logic lo);
    if (hi && !lo)      return 2'sb01;
    else if (lo && !hi) return 2'sb11;
    else                return 2'sb00;
  endfunction

  function automatic sw_code_e sw_for(input digit_t d);
    case (d)
      2'sb01:  return SW_SUB;
      2'sb11:  return SW_ADD;
      default: return SW_PASS;
    endcase
  endfunction

endpackage

// File: rtl/rsd_digit_dec.sv
module rsd_digit_dec
  import rsd_pkg::*;
(
  input  logic     cmp_hi,
  input  logic     cmp_lo,
  output digit_t   digit,
  output logic     illegal,
  output sw_code_e sw_next
);
  always_comb begin
    digit   = decide(cmp_hi, cmp_lo);
    illegal = cmp_hi & cmp_lo;
    sw_next = sw_for(digit);
  end
endmodule

// File: rtl/rsd_seq.sv
module rsd_seq #(
  parameter int NCYC = 12,
  localparam int IDX_W = (NCYC > 1) ? $clog2(NCYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  output logic             busy,
  output logic             start,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NCYC - 1);

  assign start = trig & ~busy;
  assign done  = busy & (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      busy <= ~done;
      idx  <= done ? '0 : idx + 1'b1;
    end
  end

  // R3: a running conversion advances one step per clock regardless of trig
  p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && idx == $past(idx) + 1'b1));

  // R2: the final decision ends the conversion
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R2: an idle trigger opens a conversion at step zero
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && idx == '0));
endmodule

// File: rtl/rsd_accum.sv
module rsd_accum
  import rsd_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int NCYC  = 12,
  localparam int IDX_W = (NCYC > 1) ? $clog2(NCYC) : 1,
  localparam int ACC_W = ((NCYC > RES_W) ? NCYC : RES_W) + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic             done,
  input  logic [IDX_W-1:0] idx,
  input  digit_t           digit,
  input  logic             illegal,
  output logic [RES_W-1:0] result,
  output logic             conv_err,
  output logic             data_rdy
);
  localparam logic signed [ACC_W-1:0] MID  = ACC_W'(1) <<< (RES_W - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< RES_W) - ACC_W'(1);

  // weight of the digit resolved at step i: 2^(NCYC-1-i)
  function automatic logic signed [ACC_W-1:0] weight(input logic [IDX_W-1:0] i);
    return ACC_W'(1) <<< (NCYC - 1 - int'(i));
  endfunction

  function automatic logic signed [ACC_W-1:0] add_digit(
    input logic signed [ACC_W-1:0] acc, input digit_t d, input logic [IDX_W-1:0] i);
    case (d)
      2'sb01:  return acc + weight(i);
      2'sb11:  return acc - weight(i);
      default: return acc;
    endcase
  endfunction

  function automatic logic [RES_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
    if (v < 0)         return '0;
    else if (v > MAXV) return '1;
    else               return v[RES_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] acc, acc_next;
  logic                    err_acc;

  assign acc_next = add_digit(acc, digit, idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      err_acc  <= 1'b0;
      result   <= '0;
      conv_err <= 1'b0;
      data_rdy <= 1'b0;
    end else begin
      data_rdy <= done;
      if (start) begin
        acc     <= '0;
        err_acc <= 1'b0;
      end else if (busy) begin
        acc     <= acc_next;
        err_acc <= err_acc | illegal;
      end
      if (done) begin
        result   <= clamp(acc_next + MID);
        conv_err <= err_acc | illegal;
      end
    end
  end

  // R9: ready lasts one clock
  p_rdy_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |=> !data_rdy);

  // R9: outputs held between completions
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rdy |-> ($stable(result) && $stable(conv_err)));

  // R2: ready follows the sequencer's final step
  p_rdy_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |-> $past(done));

  // R5: an illegal decision during a step is reported at completion
  p_err_carried_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |=> conv_err);
endmodule

// File: rtl/rsd_cyclic_ctrl.sv
module rsd_cyclic_ctrl
  import rsd_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int NCYC  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             cmp_hi,
  input  logic             cmp_lo,
  output logic [1:0]       sw_sel,
  output logic [RES_W-1:0] result,
  output logic             data_rdy,
  output logic             conv_err
);
  localparam int IDX_W = (NCYC > 1) ? $clog2(NCYC) : 1;

  logic             busy, start, done;
  logic [IDX_W-1:0] idx;
  digit_t           digit;
  logic             illegal;
  sw_code_e         sw_next, sw_q;

  rsd_seq #(.NCYC(NCYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig),
    .busy(busy), .start(start), .done(done), .idx(idx)
  );

  rsd_digit_dec u_dec (
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .digit(digit), .illegal(illegal), .sw_next(sw_next)
  );

  rsd_accum #(.RES_W(RES_W), .NCYC(NCYC)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .idx(idx), .digit(digit), .illegal(illegal),
    .result(result), .conv_err(conv_err), .data_rdy(data_rdy)
  );

  // switch code for the residue step that follows each decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sw_q <= SW_PASS;
    else if (busy && !done) sw_q <= sw_next;
    else                    sw_q <= SW_PASS;
  end

  assign sw_sel = sw_q;

  // R6: no reference switching outside a conversion
  p_idle_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sw_sel == SW_PASS));

  // R6: the unused code never appears
  p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sel != 2'b11);

  // R4: high comparator alone leads to subtraction
  p_hi_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && cmp_hi && !cmp_lo) |=> (sw_sel == SW_SUB));

  // R4: low comparator alone leads to addition
  p_lo_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && cmp_lo && !cmp_hi) |=> (sw_sel == SW_ADD));

  // R5: contradictory decisions leave the residue unshifted
  p_both_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmp_hi && cmp_lo) |=> (sw_sel == SW_PASS));
endmodule

// File: tb/rsd_cyclic_ctrl_tb.sv
module rsd_cyclic_ctrl_tb;
  localparam int RES_W = 12;
  localparam int NCYC  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, cmp_hi = 1'b0, cmp_lo = 1'b0;
  logic [1:0]       sw_sel;
  logic [RES_W-1:0] result;
  logic             data_rdy, conv_err;

  int vectors = 0;
  int fails   = 0;
  int rdy_seen = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rsd_cyclic_ctrl #(.RES_W(RES_W), .NCYC(NCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .sw_sel(sw_sel), .result(result), .data_rdy(data_rdy), .conv_err(conv_err)
  );

  // behavioural reference: integers stepped on the rising edge
  int m_busy = 0, m_k = 0, m_sum = 0, m_eacc = 0;
  int m_sw = 0, m_res = 0, m_rdy = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_k <= 0; m_sum <= 0; m_eacc <= 0;
      m_sw <= 0; m_res <= 0; m_rdy <= 0; m_err <= 0;
    end else if (m_busy == 0) begin
      m_rdy <= 0; m_sw <= 0;
      if (trig) begin
        m_busy <= 1; m_k <= 0; m_sum <= 0; m_eacc <= 0;
      end
    end else begin
      int d, s, e;
      d = (cmp_hi && !cmp_lo) ? 1 : ((cmp_lo && !cmp_hi) ? -1 : 0);
      e = (cmp_hi && cmp_lo) ? 1 : 0;
      s = m_sum + d * (1 << (NCYC - 1 - m_k));
      m_sum  <= s;
      m_eacc <= m_eacc | e;
      if (m_k == NCYC - 1) begin
        int v;
        v = s + (1 << (RES_W - 1));
        if (v < 0) v = 0;
        if (v > (1 << RES_W) - 1) v = (1 << RES_W) - 1;
        m_busy <= 0; m_k <= 0; m_rdy <= 1; m_sw <= 0;
        m_res <= v; m_err <= m_eacc | e;
      end else begin
        m_rdy <= 0;
        m_sw  <= (d == 1) ? 1 : ((d == -1) ? 2 : 0);
        m_k   <= m_k + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(int'(sw_sel) == m_sw, "R6 sw_sel", int'(sw_sel), m_sw);
      check(int'(result) == m_res, "R7 result", int'(result), m_res);
      check(int'(data_rdy) == m_rdy, "R2 data_rdy", int'(data_rdy), m_rdy);
      check(int'(conv_err) == m_err, "R5 conv_err", int'(conv_err), m_err);
      if (data_rdy) rdy_seen++;
    end
  end

  // closed-form expected word from the digit codes (0 none, 1 hi, 2 lo, 3 both)
  function automatic int word_of(input logic [2*NCYC-1:0] codes);
    int s = 1 << (RES_W - 1);
    for (int i = 0; i < NCYC; i++) begin
      if (codes[2*i +: 2] == 2'd1) s += 1 << (NCYC - 1 - i);
      if (codes[2*i +: 2] == 2'd2) s -= 1 << (NCYC - 1 - i);
    end
    if (s < 0) s = 0;
    if (s > (1 << RES_W) - 1) s = (1 << RES_W) - 1;
    return s;
  endfunction

  task automatic convert(input logic [2*NCYC-1:0] codes, input bit hold_trig,
                         input bit exp_err, input string req);
    int exp_w, rdy0;
    exp_w = word_of(codes);
    @(negedge clk); trig = 1'b1; cmp_hi = 1'b0; cmp_lo = 1'b0;
    rdy0 = rdy_seen;
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      trig = hold_trig;
      {cmp_lo, cmp_hi} = codes[2*i +: 2];
    end
    @(negedge clk); trig = 1'b0; cmp_hi = 1'b0; cmp_lo = 1'b0;
    check(data_rdy == 1'b1, "R2 ready timing", int'(data_rdy), 1);
    check(int'(result) == exp_w, req, int'(result), exp_w);
    check(int'(conv_err) == int'(exp_err), "R5 error flag", int'(conv_err), int'(exp_err));
    @(negedge clk);
    check(data_rdy == 1'b0, "R9 single pulse", int'(data_rdy), 0);
    check(int'(result) == exp_w, "R9 result held", int'(result), exp_w);
    check(rdy_seen - rdy0 == 1, "R3 one completion", rdy_seen - rdy0, 1);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [2*NCYC-1:0] fill(input logic [1:0] c);
    logic [2*NCYC-1:0] v;
    for (int i = 0; i < NCYC; i++) v[2*i +: 2] = c;
    return v;
  endfunction

  initial begin
    logic [2*NCYC-1:0] codes;
    repeat (3) @(negedge clk);
    check(sw_sel == 2'b00 && result == '0 && !data_rdy && !conv_err,
          "R1 reset state", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sw_sel == 2'b00 && result == '0 && !data_rdy && !conv_err,
          "R1 after release", int'(sw_sel), 0);

    convert(fill(2'd0), 1'b0, 1'b0, "R7 all zero digits");
    convert(fill(2'd1), 1'b0, 1'b0, "R8 clamp high");
    convert(fill(2'd2), 1'b0, 1'b0, "R8 clamp low");
    codes = fill(2'd2); codes[1:0] = 2'd1;
    convert(codes, 1'b0, 1'b0, "R7 plus then minus");
    codes = fill(2'd0); codes[1:0] = 2'd1; codes[3:2] = 2'd2;
    convert(codes, 1'b0, 1'b0, "R4 redundant pair");
    codes = 24'b01_10_00_01_10_01_00_00_10_01_10_01;
    convert(codes, 1'b0, 1'b0, "R4 mixed digits");
    codes = fill(2'd0); codes[5:4] = 2'd3; codes[1:0] = 2'd1;
    convert(codes, 1'b0, 1'b1, "R5 both comparators");
    convert(fill(2'd0), 1'b0, 1'b0, "R5 flag cleared");
    codes = 24'b10_01_01_00_10_10_01_00_01_10_00_01;
    convert(codes, 1'b1, 1'b0, "R3 trigger while busy");
    codes = fill(2'd1); codes[1:0] = 2'd2;
    convert(codes, 1'b0, 1'b0, "R7 minus then plus");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      vectors++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule